// File: doc/BRIEF.md
# Serial Flash Command Front End

This block is the slave side of the serial interface of a flash device. It watches chip select, serial clock and serial input, all sampled in the device's own clock domain. It builds bytes from the serial input, most significant bit first, and decodes the first byte of each selection as an opcode. Using a built-in framing table, it then collects the address bytes and any don't-care byte that the opcode needs, and hands the command onward as a one-cycle dispatch pulse with the opcode and the address.

Bytes that follow the header of a non-read command are passed on one strobe each. For the two array read opcodes, the block takes over the serial output and streams bytes from an internal pointer that counts up by one per byte. The byte value comes from the array through a combinational read port. When chip select is released after a dispatched command, the block reports an end event. That event carries a flag telling whether the release fell on a byte boundary, so the engines behind the block can reject partial data. Both idle clock levels, low and high, are accepted.

Top module: `spi_flash_front`

## Requirements
- R1: The first 8 bits after chip select falls, taken on rising serial clock edges with the MSB first, form the opcode. Opcodes 06h, 04h, B9h, ABh, 60h, C7h, 05h, 9Fh and 01h carry no address. Each is dispatched at once with one `cmd_valid_o` pulse, and `addr_o` is zero.
- R2: Opcodes 20h, 52h, D8h, 36h, 39h, 02h and 03h are dispatched after three address bytes, sent MSB first. `addr_o` carries the low 20 address bits, and bits 23..20 read as zero.
- R3: Opcode 0Bh needs one don't-care byte after its three address bytes before it is dispatched. Opcode 03h needs none.
- R4: An opcode not listed in R1 to R3 causes no dispatch, no data strobe and no end event. Every later bit up to the release of chip select is also ignored, even bits that form a valid opcode.
- R5: If chip select rises before the opcode, address and don't-care bytes are complete, there is no dispatch and no end event.
- R6: After a non-read command is dispatched, each further complete byte appears on `data_o` with a one-cycle `data_valid_o` strobe.
- R7: After a read is dispatched, `so_o` changes only on falling serial clock edges. It presents the array byte at the start address MSB first, then the bytes at the following addresses, so a bit is valid at each rising edge.
- R8: The read pointer wraps from 0FFFFFh to 000000h with no gap in the bit stream.
- R9: `so_oe_o` is low while chip select is high and during the header. It is high while a read streams.
- R10: When chip select rises after a dispatch, `end_o` pulses once. `end_aligned_o` is 1 if a whole number of bytes was clocked and 0 otherwise. Release may come in the middle of a byte.
- R11: Framing and data behave the same whether the serial clock idles low or idles high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Device clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low, synchronous to clk_i |
| sck_i | input | 1 | Serial clock level, synchronous to clk_i |
| si_i | input | 1 | Serial data in |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Output enable for so_o |
| cmd_valid_o | output | 1 | One-cycle command dispatch pulse |
| cmd_o | output | 8 | Dispatched opcode |
| addr_o | output | ADDR_W | Dispatched address, upper bits zero |
| data_valid_o | output | 1 | Data byte strobe |
| data_o | output | 8 | Received data byte |
| end_o | output | 1 | Chip select released after a dispatch |
| end_aligned_o | output | 1 | Release fell on a byte boundary |
| rd_addr_o | output | ARRAY_AW | Array read address |
| rd_data_i | input | 8 | Array byte at rd_addr_o |

## Verification
The properties assume that chip select, serial clock and serial input already come synchronous to `clk_i`. They also assume each serial clock level is held for at least three device clocks, so that a byte completion can settle into the sequencer before the next edge. The bench drives every level for four device clocks and switches chip select only while the serial clock is steady. It changes the clock level only while chip select is high, which keeps the idle-high and idle-low runs free of spurious edges. One sweep covers all 256 opcodes, each with four trailing bytes, and checks the dispatch, strobe and end counts against a framing table that the bench writes out itself.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;

  typedef enum logic [2:0] {
    ST_OPC,
    ST_ADDR,
    ST_DUMMY,
    ST_DATA,
    ST_SKIP
  } fe_state_e;

  typedef struct packed {
    logic       known;
    logic [1:0] n_addr;
    logic       dummy;
    logic       stream;
  } frame_t;

  function automatic frame_t frame_lookup(input logic [7:0] op);
    frame_t f;
    f = '0;
    case (op)
      8'h0B:                             f = '{known: 1'b1, n_addr: 2'd3, dummy: 1'b1, stream: 1'b1};
      8'h03:                             f = '{known: 1'b1, n_addr: 2'd3, dummy: 1'b0, stream: 1'b1};
      8'h20, 8'h52, 8'hD8, 8'h36, 8'h39,
      8'h02:                             f = '{known: 1'b1, n_addr: 2'd3, dummy: 1'b0, stream: 1'b0};
      8'h06, 8'h04, 8'hB9, 8'hAB, 8'h60,
      8'hC7, 8'h05, 8'h9F, 8'h01:        f = '{known: 1'b1, n_addr: 2'd0, dummy: 1'b0, stream: 1'b0};
      default:                           f = '0;
    endcase
    return f;
  endfunction

endpackage

// File: rtl/spi_fe_shift.sv
module spi_fe_shift (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_ni,
  input  logic       sck_i,
  input  logic       si_i,
  output logic       sck_fall_o,
  output logic       cs_rel_o,
  output logic [2:0] bit_cnt_o,
  output logic       byte_v_o,
  output logic [7:0] byte_o
);
  logic       sck_q, cs_q;
  logic [6:0] sr;
  logic       sck_rise;

  assign sck_rise   = sck_i & ~sck_q & ~cs_ni;
  assign sck_fall_o = ~sck_i & sck_q & ~cs_ni;
  assign cs_rel_o   = cs_ni & ~cs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q     <= 1'b0;
      cs_q      <= 1'b1;
      sr        <= '0;
      bit_cnt_o <= '0;
      byte_v_o  <= 1'b0;
      byte_o    <= '0;
    end else begin
      sck_q    <= sck_i;
      cs_q     <= cs_ni;
      byte_v_o <= 1'b0;
      if (cs_ni) begin
        bit_cnt_o <= '0;
      end else if (sck_rise) begin
        sr        <= {sr[5:0], si_i};
        bit_cnt_o <= bit_cnt_o + 3'd1;
        if (bit_cnt_o == 3'd7) begin
          byte_v_o <= 1'b1;
          byte_o   <= {sr, si_i};
        end
      end
    end
  end
endmodule

// File: rtl/spi_fe_seq.sv
module spi_fe_seq
  import spi_fe_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int ARRAY_AW = 20
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cs_ni,
  input  logic                cs_rel_i,
  input  logic [2:0]          bit_cnt_i,
  input  logic                byte_v_i,
  input  logic [7:0]          byte_i,
  output logic                cmd_valid_o,
  output logic [7:0]          cmd_o,
  output logic [ADDR_W-1:0]   addr_o,
  output logic                data_valid_o,
  output logic [7:0]          data_o,
  output logic                end_o,
  output logic                end_aligned_o,
  output logic                stream_o,
  output logic                start_o,
  output logic [ARRAY_AW-1:0] start_addr_o
);
  localparam int PadW = ADDR_W - ARRAY_AW;

  fe_state_e           state;
  frame_t              frame_q, frm;
  logic [7:0]          opc;
  logic [1:0]          acnt;
  logic [ARRAY_AW-1:0] addr_acc, addr_nxt;
  logic                hdr_last;

  assign frm      = frame_lookup(byte_i);
  assign addr_nxt = ARRAY_AW'({addr_acc, byte_i});
  assign hdr_last = (state == ST_ADDR && acnt == 2'd1 && !frame_q.dummy) || state == ST_DUMMY;
  assign stream_o = state == ST_DATA && frame_q.known && frame_q.stream;
  assign start_o  = byte_v_i && !cs_ni && frame_q.stream && hdr_last;
  assign start_addr_o = (state == ST_DUMMY) ? addr_acc : addr_nxt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state         <= ST_OPC;
      frame_q       <= '0;
      opc           <= '0;
      acnt          <= '0;
      addr_acc      <= '0;
      cmd_valid_o   <= 1'b0;
      cmd_o         <= '0;
      addr_o        <= '0;
      data_valid_o  <= 1'b0;
      data_o        <= '0;
      end_o         <= 1'b0;
      end_aligned_o <= 1'b0;
    end else begin
      cmd_valid_o  <= 1'b0;
      data_valid_o <= 1'b0;
      end_o        <= 1'b0;
      if (cs_rel_i) begin
        end_o         <= state == ST_DATA;
        end_aligned_o <= bit_cnt_i == 3'd0;
      end
      if (cs_ni) begin
        state   <= ST_OPC;
        frame_q <= '0;
      end else if (byte_v_i) begin
        case (state)
          ST_OPC: begin
            if (!frm.known) begin
              state <= ST_SKIP;
            end else begin
              opc     <= byte_i;
              frame_q <= frm;
              acnt    <= frm.n_addr;
              if (frm.n_addr == 2'd0) begin
                state       <= ST_DATA;
                cmd_valid_o <= 1'b1;
                cmd_o       <= byte_i;
                addr_o      <= '0;
              end else begin
                state <= ST_ADDR;
              end
            end
          end
          ST_ADDR: begin
            addr_acc <= addr_nxt;
            acnt     <= acnt - 2'd1;
            if (acnt == 2'd1) begin
              if (frame_q.dummy) begin
                state <= ST_DUMMY;
              end else begin
                state       <= ST_DATA;
                cmd_valid_o <= 1'b1;
                cmd_o       <= opc;
                addr_o      <= {{PadW{1'b0}}, addr_nxt};
              end
            end
          end
          ST_DUMMY: begin
            state       <= ST_DATA;
            cmd_valid_o <= 1'b1;
            cmd_o       <= opc;
            addr_o      <= {{PadW{1'b0}}, addr_acc};
          end
          ST_DATA: begin
            if (!frame_q.stream) begin
              data_valid_o <= 1'b1;
              data_o       <= byte_i;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_fe_rdstream.sv
module spi_fe_rdstream #(
  parameter int ARRAY_AW = 20
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [ARRAY_AW-1:0] start_addr_i,
  input  logic                active_i,
  input  logic                sck_fall_i,
  input  logic [2:0]          bit_cnt_i,
  input  logic [7:0]          rd_data_i,
  output logic [ARRAY_AW-1:0] rd_addr_o,
  output logic                so_o
);
  logic [7:0] sr;

  assign so_o = sr[7];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr        <= '0;
      rd_addr_o <= '0;
    end else if (start_i) begin
      rd_addr_o <= start_addr_i;
    end else if (active_i && sck_fall_i) begin
      // byte boundary: fetch and advance, natural wrap at array top
      if (bit_cnt_i == 3'd0) begin
        sr        <= rd_data_i;
        rd_addr_o <= rd_addr_o + ARRAY_AW'(1);
      end else begin
        sr <= {sr[6:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/spi_flash_front.sv
module spi_flash_front #(
  parameter int ADDR_W   = 24,
  parameter int ARRAY_AW = 20
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cs_ni,
  input  logic                sck_i,
  input  logic                si_i,
  output logic                so_o,
  output logic                so_oe_o,
  output logic                cmd_valid_o,
  output logic [7:0]          cmd_o,
  output logic [ADDR_W-1:0]   addr_o,
  output logic                data_valid_o,
  output logic [7:0]          data_o,
  output logic                end_o,
  output logic                end_aligned_o,
  output logic [ARRAY_AW-1:0] rd_addr_o,
  input  logic [7:0]          rd_data_i
);
  logic                sck_fall, cs_rel, byte_v, stream, start;
  logic [2:0]          bit_cnt;
  logic [7:0]          byte_w;
  logic [ARRAY_AW-1:0] start_addr;

  assign so_oe_o = stream;

  spi_fe_shift u_shift (
    .clk_i, .rst_ni, .cs_ni, .sck_i, .si_i,
    .sck_fall_o (sck_fall),
    .cs_rel_o   (cs_rel),
    .bit_cnt_o  (bit_cnt),
    .byte_v_o   (byte_v),
    .byte_o     (byte_w)
  );

  spi_fe_seq #(.ADDR_W(ADDR_W), .ARRAY_AW(ARRAY_AW)) u_seq (
    .clk_i, .rst_ni, .cs_ni,
    .cs_rel_i      (cs_rel),
    .bit_cnt_i     (bit_cnt),
    .byte_v_i      (byte_v),
    .byte_i        (byte_w),
    .cmd_valid_o, .cmd_o, .addr_o, .data_valid_o, .data_o,
    .end_o, .end_aligned_o,
    .stream_o      (stream),
    .start_o       (start),
    .start_addr_o  (start_addr)
  );

  spi_fe_rdstream #(.ARRAY_AW(ARRAY_AW)) u_rd (
    .clk_i, .rst_ni,
    .start_i      (start),
    .start_addr_i (start_addr),
    .active_i     (stream),
    .sck_fall_i   (sck_fall),
    .bit_cnt_i    (bit_cnt),
    .rd_data_i,
    .rd_addr_o,
    .so_o
  );
endmodule

// File: rtl/spi_flash_front_chk.sv
module spi_flash_front_chk #(
  parameter int ARRAY_AW = 20
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                cs_ni,
  input logic                so_oe_o,
  input logic                cmd_valid_o,
  input logic                data_valid_o,
  input logic                end_o,
  input logic [ARRAY_AW-1:0] rd_addr_o
);
  // R9
  oe_off_when_deselected_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni && $past(cs_ni)) |-> !so_oe_o);

  // R1
  dispatch_single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |=> !cmd_valid_o);

  // R10
  end_follows_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_o |-> ($past(cs_ni) && !$past(cs_ni, 2)));

  // R8
  rd_ptr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(so_oe_o) && so_oe_o && rd_addr_o != $past(rd_addr_o))
      |-> rd_addr_o == $past(rd_addr_o) + ARRAY_AW'(1));

  // R6
  no_strobe_in_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_valid_o |-> !so_oe_o);
endmodule

bind spi_flash_front spi_flash_front_chk #(.ARRAY_AW(ARRAY_AW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cs_ni        (cs_ni),
  .so_oe_o      (so_oe_o),
  .cmd_valid_o  (cmd_valid_o),
  .data_valid_o (data_valid_o),
  .end_o        (end_o),
  .rd_addr_o    (rd_addr_o)
);

// File: tb/spi_flash_front_tb_top.sv
module spi_flash_front_tb_top;
  localparam int ADDR_W   = 24;
  localparam int ARRAY_AW = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0;
  logic so, so_oe, cmd_valid, data_valid, end_p, end_al;
  logic [7:0] cmd, data;
  logic [ADDR_W-1:0] addr;
  logic [ARRAY_AW-1:0] rd_addr;
  logic [7:0] rd_data;

  int checks = 0, errors = 0;
  int n_cmd = 0, n_data = 0, n_end = 0;
  logic [7:0] last_cmd = '0;
  logic [ADDR_W-1:0] last_addr = '0;
  logic last_al = 1'b0;
  logic [7:0] dbuf [16];
  bit mode3 = 1'b0;

  always #10 clk = ~clk;

  function automatic logic [7:0] mem_f(input logic [ARRAY_AW-1:0] a);
    return a[7:0] ^ {a[11:8], a[19:16]} ^ 8'h5C;
  endfunction
  assign rd_data = mem_f(rd_addr);

  spi_flash_front #(.ADDR_W(ADDR_W), .ARRAY_AW(ARRAY_AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .si_i(si),
    .so_o(so), .so_oe_o(so_oe), .cmd_valid_o(cmd_valid), .cmd_o(cmd),
    .addr_o(addr), .data_valid_o(data_valid), .data_o(data),
    .end_o(end_p), .end_aligned_o(end_al), .rd_addr_o(rd_addr), .rd_data_i(rd_data)
  );

  always @(negedge clk) if (rst_n) begin
    if (cmd_valid) begin n_cmd++; last_cmd = cmd; last_addr = addr; end
    if (data_valid) begin dbuf[n_data % 16] = data; n_data++; end
    if (end_p) begin n_end++; last_al = end_al; end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic start(input bit m3);
    sck = m3;
    wait_clk(2);
    mode3 = m3;
    cs_n = 1'b0;
    wait_clk(4);
  endtask

  task automatic stop();
    if (!mode3) begin sck = 1'b0; wait_clk(4); end
    cs_n = 1'b1;
    wait_clk(6);
  endtask

  task automatic xbits(input logic [7:0] b, input int n, output logic [7:0] rx, output logic oe_any);
    rx = '0; oe_any = 1'b0;
    for (int i = 7; i > 7 - n; i--) begin
      sck = 1'b0; si = b[i];
      wait_clk(4);
      rx[i] = so; oe_any |= so_oe;
      sck = 1'b1;
      wait_clk(4);
    end
  endtask

  task automatic xb(input logic [7:0] b);
    logic [7:0] r; logic o;
    xbits(b, 8, r, o);
  endtask

  function automatic void exp_frame(input logic [7:0] op, output bit kn, output int na,
                                    output int dm, output bit st);
    kn = 1'b1; na = 0; dm = 0; st = 1'b0;
    case (op)
      8'h0B: begin na = 3; dm = 1; st = 1'b1; end
      8'h03: begin na = 3; st = 1'b1; end
      8'h20, 8'h52, 8'hD8, 8'h36, 8'h39, 8'h02: na = 3;
      8'h06, 8'h04, 8'hB9, 8'hAB, 8'h60, 8'hC7, 8'h05, 8'h9F, 8'h01: na = 0;
      default: kn = 1'b0;
    endcase
  endfunction

  // R1 R2 R3 R4 R11: every opcode followed by four zero bytes
  task automatic sweep();
    for (int op = 0; op < 256; op++) begin
      logic [7:0] o;
      bit kn, st; int na, dm, c0, d0, e0, ec, ed, ee;
      bit ok;
      o = 8'(op);
      exp_frame(o, kn, na, dm, st);
      c0 = n_cmd; d0 = n_data; e0 = n_end;
      start(o[0]);
      xb(o); xb(8'h00); xb(8'h00); xb(8'h00); xb(8'h00);
      stop();
      ec = kn ? 1 : 0;
      ee = ec;
      ed = (kn && !st) ? 4 - na - dm : 0;
      ok = (n_cmd - c0 == ec) && (n_data - d0 == ed) && (n_end - e0 == ee) &&
           (!kn || (last_cmd == o && last_addr == '0));
      check(ok, $sformatf("R1 R2 R3 R4 R11 sweep op=%02h", o),
            32'({8'(n_cmd - c0), 8'(n_data - d0), 8'(n_end - e0)}),
            32'({8'(ec), 8'(ed), 8'(ee)}));
    end
  endtask

  task automatic read_test(input bit m3, input logic [7:0] op, input logic [23:0] a,
                           input int nbytes, input string tag);
    logic [7:0] r; logic o; logic oe_hdr;
    logic [ARRAY_AW-1:0] p;
    int c0;
    c0 = n_cmd; oe_hdr = 1'b0;
    start(m3);
    xbits(op, 8, r, o); oe_hdr |= o;
    xbits(a[23:16], 8, r, o); oe_hdr |= o;
    xbits(a[15:8], 8, r, o); oe_hdr |= o;
    xbits(a[7:0], 8, r, o); oe_hdr |= o;
    if (op == 8'h0B) begin xbits(8'hFF, 8, r, o); oe_hdr |= o; end
    check(oe_hdr == 1'b0, {"R9 header oe ", tag}, 32'(oe_hdr), 32'd0);
    check(n_cmd - c0 == 1 && last_cmd == op && last_addr == {4'h0, a[19:0]},
          {"R2 R3 read dispatch ", tag}, 32'(last_addr), 32'({4'h0, a[19:0]}));
    p = a[19:0];
    for (int k = 0; k < nbytes; k++) begin
      xbits(8'h00, 8, r, o);
      check(r == mem_f(p), $sformatf("R7 R8 R11 read byte %0d %s", k, tag), 32'(r), 32'(mem_f(p)));
      check(o == 1'b1, {"R9 stream oe ", tag}, 32'(o), 32'd1);
      p = p + ARRAY_AW'(1);
    end
  endtask

  initial begin
    logic [7:0] r; logic o;
    int c0, e0, d0;
    wait_clk(3);
    check(so_oe == 1'b0 && cmd_valid == 1'b0 && data_valid == 1'b0 && end_p == 1'b0,
          "R9 reset state", 32'({so_oe, cmd_valid, data_valid, end_p}), 32'd0);
    rst_n = 1'b1;
    wait_clk(4);

    // R7 mode 0 plain read, R10 aligned end
    e0 = n_end;
    read_test(1'b0, 8'h03, 24'h000100, 4, "m0");
    stop();
    check(n_end - e0 == 1 && last_al == 1'b1, "R10 end aligned after read", 32'(last_al), 32'd1);
    check(so_oe == 1'b0, "R9 oe low after release", 32'(so_oe), 32'd0);

    // R3 R11 mode 3 read with don't-care byte, upper address bits ignored
    read_test(1'b1, 8'h0B, 24'h3ABCDE, 3, "m3");
    stop();

    // R8 wrap across array top, then release mid-byte
    e0 = n_end;
    read_test(1'b0, 8'h03, 24'h0FFFFE, 4, "wrap");
    xbits(8'h00, 4, r, o);
    stop();
    check(n_end - e0 == 1 && last_al == 1'b0, "R10 mid-byte read release", 32'(last_al), 32'd0);

    // R6 data bytes after program header
    c0 = n_cmd; d0 = n_data;
    start(1'b0);
    xb(8'h02); xb(8'hF1); xb(8'h23); xb(8'h45);
    xb(8'h11); xb(8'h22); xb(8'h33);
    stop();
    check(n_cmd - c0 == 1 && last_addr == 24'h012345, "R2 program addr", 32'(last_addr), 32'h012345);
    check(n_data - d0 == 3, "R6 strobe count", 32'(n_data - d0), 32'd3);
    check(dbuf[d0 % 16] == 8'h11 && dbuf[(d0 + 1) % 16] == 8'h22 && dbuf[(d0 + 2) % 16] == 8'h33,
          "R6 data values", 32'({dbuf[d0 % 16], dbuf[(d0 + 1) % 16], dbuf[(d0 + 2) % 16]}), 32'h112233);

    // R10 unaligned release after no-address command
    e0 = n_end;
    start(1'b1);
    xb(8'h06);
    xbits(8'hA0, 3, r, o);
    stop();
    check(n_end - e0 == 1 && last_al == 1'b0, "R10 unaligned end", 32'(last_al), 32'd0);

    // R5 early releases
    c0 = n_cmd; e0 = n_end;
    start(1'b0); xb(8'h20); xb(8'h00); xb(8'h10); stop();
    start(1'b1); xb(8'h0B); xb(8'h00); xb(8'h10); xb(8'h20); stop();
    start(1'b0); xbits(8'h06, 5, r, o); stop();
    check(n_cmd == c0, "R5 no dispatch on abort", 32'(n_cmd - c0), 32'd0);
    check(n_end == e0, "R5 no end on abort", 32'(n_end - e0), 32'd0);

    // R4 unknown opcode swallows following valid opcode; next selection recovers
    c0 = n_cmd; e0 = n_end; d0 = n_data;
    start(1'b0); xb(8'h77); xb(8'h06); xb(8'h20); xb(8'h00); stop();
    check(n_cmd == c0 && n_end == e0 && n_data == d0, "R4 ignored until release",
          32'(n_cmd - c0 + n_end - e0 + n_data - d0), 32'd0);
    start(1'b0); xb(8'h06); stop();
    check(n_cmd - c0 == 1 && last_cmd == 8'h06, "R1 R4 recovery dispatch", 32'(last_cmd), 32'h06);

    sweep();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule